// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Bank

This block holds the control and status registers for a bank of general-purpose I/O ports and sits on a simple synchronous register bus: a byte address, 32-bit write data, a write strobe, a read strobe and registered read data. Each port is eight pins wide by default. Every pin can be an input or an output, and software can drive its output level or read its live level back. Each pin also has a function-select field. When that field is not zero, the pin is handed to some other function outside this block. In that case the block only exports the selection and turns off its own GPIO drive.

Output levels change in three ways: through the data register, through a write-one-to-set register, and through a write-one-to-clear register. With the last two, software never needs a read-modify-write cycle. The data register also returns the live synchronized pin levels and a snapshot of the pin levels taken as reset ends. A per-port pull-up register enables the pad pull-ups. Ports listed in a parameter mask have no pull-up control.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and after it is released, every pin is an input (`pin_oe`=0), every output level and function-select field is 0, and `pin_pull` is all ones on ports with pull-up control and zero elsewhere.
- R2: A write to port p's data register (byte address 0x20+0x10·p) loads the direction from bits [31:24] (1 = output) and the output level from bits [23:16]. Bits [15:0] are ignored. The new `pin_oe`/`pin_out` are visible after that clock edge, and a read returns the new fields.
- R3: A write to the set register (data address + 4) raises every output bit whose write-data bit [i] is 1 and leaves the others unchanged.
- R4: A write to the clear register (data address + 8) lowers every output bit whose write-data bit [i] is 1 and leaves the others unchanged.
- R5: Data register bits [15:8] return the synchronized pin levels captured on the first clock edge after reset is released. They stay unchanged until the next reset.
- R6: Data register bits [7:0] return pin levels through a two-stage synchronizer. A change at the pins shows up on a read whose strobe is sampled at the third rising edge after the change, and not before.
- R7: The function-select register of port p sits at byte address 4·p and holds 2 bits per pin (pin i at bits [2i+1:2i]). The fields are exported on `pin_fsel`. A nonzero field forces that pin's `pin_oe` and `pin_out` to 0 without changing the direction or level stored for it.
- R8: The pull-up register (data address + 12) holds one enable per pin in bits [7:0] and drives `pin_pull`. On ports 2 and 4 this register reads as zero, writes to it are ignored, and `pin_pull` stays 0.
- R9: The set and clear registers read as zero. Reads return zero, and writes have no effect, at misaligned addresses, at 0x14–0x1F and at addresses at or above 0x70.
- R10: Read data is registered. It appears in the cycle after the read strobe and is zero in any cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 40 | Raw pin levels, port p at [8p+7:8p] |
| pin_oe | output | 40 | Output enable per pin |
| pin_out | output | 40 | Output level per pin |
| pin_pull | output | 40 | Pull-up enable per pin |
| pin_fsel | output | 80 | Function select, 2 bits per pin |

## Verification
Register writes take effect on the edge that samples the strobe, so `pin_oe`, `pin_out`, `pin_pull` and `pin_fsel` are due just after that edge. Read data is due one edge after the read strobe. A pin change reaches the live field only after two synchronizer edges. The bench keeps a behavioural model that applies these latencies in its own variables at each rising edge, and it compares every output 2 ns after that edge. Directed reads sample `bus_rdata` on the falling edge that follows the strobe edge. One directed read is issued on purpose right after a pin change, to confirm the old level is still returned.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned DIR_LSB    = 24;
   localparam int unsigned LVL_LSB    = 16;
   localparam int unsigned SNAP_LSB   = 8;
   localparam int unsigned LIVE_LSB   = 0;
   localparam int unsigned PORT_BASE  = 32;
   localparam int unsigned PORT_SPAN  = 16;

   typedef enum logic [1:0] {
      SLOT_DATA = 2'd0,
      SLOT_SET  = 2'd1,
      SLOT_CLR  = 2'd2,
      SLOT_PULL = 2'd3
   } port_slot_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) chain[0] <= d;

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned PW       = 8,
   parameter int unsigned FSW      = 2,
   parameter bit          HAS_PULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fs,
   input  logic              wr_dat,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic              wr_par,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [PW-1:0]     pins_s,
   input  logic              snap_en,
   output logic [PW*FSW-1:0] fsel_o,
   output logic [PW-1:0]     oe_o,
   output logic [PW-1:0]     out_o,
   output logic [PW-1:0]     pull_o,
   output logic [BUS_W-1:0]  fs_word,
   output logic [BUS_W-1:0]  dat_word,
   output logic [BUS_W-1:0]  par_word
);
   localparam int unsigned FSB = PW * FSW;

   if (PW > 8) begin : g_bad_pw
      $error("gpio_port: PW must not exceed the 8-bit data fields");
   end
   if (FSB > BUS_W) begin : g_bad_fsw
      $error("gpio_port: function-select fields exceed the bus width");
   end

   logic [FSB-1:0] fs_q;
   logic [PW-1:0]  dir_q, lvl_q, snap_q, mask_w;

   assign mask_w = wdata[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q   <= '0;
         dir_q  <= '0;
         lvl_q  <= '0;
         snap_q <= '0;
      end else begin
         if (wr_fs)   fs_q   <= wdata[FSB-1:0];
         if (wr_dat)  dir_q  <= wdata[DIR_LSB +: PW];
         if (snap_en) snap_q <= pins_s;
         if (wr_dat)      lvl_q <= wdata[LVL_LSB +: PW];
         else if (wr_clr) lvl_q <= lvl_q & ~mask_w;
         else if (wr_set) lvl_q <= lvl_q | mask_w;
      end
   end

   for (genvar i = 0; i < PW; i++) begin : g_pin
      logic is_gpio;
      assign is_gpio  = (fs_q[i*FSW +: FSW] == '0);
      assign oe_o[i]  = dir_q[i] & is_gpio;
      assign out_o[i] = lvl_q[i] & is_gpio;
   end

   if (HAS_PULL) begin : g_pull
      logic [PW-1:0] pu_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pu_q <= '1;
         else if (wr_par) pu_q <= mask_w;
      end
      assign pull_o = pu_q;
   end else begin : g_nopull
      logic unused_par;
      assign unused_par = wr_par;
      assign pull_o     = '0;
   end

   always_comb begin
      fs_word  = '0;
      dat_word = '0;
      par_word = '0;
      fs_word[FSB-1:0]          = fs_q;
      dat_word[DIR_LSB  +: PW]  = dir_q;
      dat_word[LVL_LSB  +: PW]  = lvl_q;
      dat_word[SNAP_LSB +: PW]  = snap_q;
      dat_word[LIVE_LSB +: PW]  = pins_s;
      par_word[PW-1:0]          = pull_o;
   end

   assign fsel_o = fs_q;

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // R3: a set write never lowers a bit and raises every masked bit
   p_set_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && !wr_dat && !wr_clr) |=>
         (((lvl_q & $past(lvl_q)) == $past(lvl_q)) &&
          ((lvl_q & $past(mask_w)) == $past(mask_w))));

   // R4: a clear write never raises a bit and lowers every masked bit
   p_clr_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !wr_dat) |=>
         (((lvl_q | $past(lvl_q)) == $past(lvl_q)) &&
          ((lvl_q & $past(mask_w)) == '0)));

   // R5: once captured, the reset snapshot holds
   p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_en |=> $stable(snap_q));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int unsigned NP        = 5,
   parameter int unsigned PW        = 8,
   parameter int unsigned FSW       = 2,
   parameter int unsigned AW        = 8,
   parameter int unsigned SYNC_STG  = 2,
   parameter int unsigned PULL_MASK = 32'h0000_000B
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [AW-1:0]         bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic [NP*PW-1:0]      pin_in,
   output logic [NP*PW-1:0]      pin_oe,
   output logic [NP*PW-1:0]      pin_out,
   output logic [NP*PW-1:0]      pin_pull,
   output logic [NP*PW*FSW-1:0]  pin_fsel
);
   localparam int unsigned NPIN    = NP * PW;
   localparam int unsigned TOP_END = PORT_BASE + NP * PORT_SPAN;

   if (NP * 4 > PORT_BASE) begin : g_bad_np
      $error("gpio_bank: function-select block overlaps the port block");
   end
   if (TOP_END > (1 << AW)) begin : g_bad_aw
      $error("gpio_bank: address width too small for the port count");
   end

   // ---------------- decode ----------------
   logic          hit, is_fs;
   logic [AW-1:0] idx, off;
   port_slot_e    slot;

   always_comb begin
      hit   = 1'b0;
      is_fs = 1'b0;
      off   = bus_addr - AW'(PORT_BASE);
      idx   = '0;
      slot  = SLOT_DATA;
      if (bus_addr[1:0] == 2'b00) begin
         if (bus_addr < AW'(PORT_BASE)) begin
            idx   = bus_addr >> 2;
            is_fs = 1'b1;
            hit   = (idx < AW'(NP));
         end else begin
            idx  = off >> 4;
            slot = port_slot_e'(off[3:2]);
            hit  = (idx < AW'(NP));
         end
      end
   end

   // ---------------- synchronizer and snapshot ----------------
   logic [NPIN-1:0] pins_s;
   logic            snap_done;

   gpio_sync #(.W(NPIN), .STAGES(SYNC_STG)) sync_i (
      .clk (clk),
      .d   (pin_in),
      .q   (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_done <= 1'b0;
      else        snap_done <= 1'b1;
   end

   // ---------------- ports ----------------
   logic [BUS_W-1:0] fs_words  [NP];
   logic [BUS_W-1:0] dat_words [NP];
   logic [BUS_W-1:0] par_words [NP];

   for (genvar p = 0; p < NP; p++) begin : g_port
      logic sel, sel_reg;
      assign sel     = bus_wr & hit & (idx == AW'(p));
      assign sel_reg = sel & ~is_fs;

      gpio_port #(
         .PW       (PW),
         .FSW      (FSW),
         .HAS_PULL (PULL_MASK[p])
      ) port_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_fs    (sel & is_fs),
         .wr_dat   (sel_reg & (slot == SLOT_DATA)),
         .wr_set   (sel_reg & (slot == SLOT_SET)),
         .wr_clr   (sel_reg & (slot == SLOT_CLR)),
         .wr_par   (sel_reg & (slot == SLOT_PULL)),
         .wdata    (bus_wdata),
         .pins_s   (pins_s[p*PW +: PW]),
         .snap_en  (~snap_done),
         .fsel_o   (pin_fsel[p*PW*FSW +: PW*FSW]),
         .oe_o     (pin_oe[p*PW +: PW]),
         .out_o    (pin_out[p*PW +: PW]),
         .pull_o   (pin_pull[p*PW +: PW]),
         .fs_word  (fs_words[p]),
         .dat_word (dat_words[p]),
         .par_word (par_words[p])
      );
   end

   // ---------------- read path ----------------
   logic [BUS_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < NP; p++) begin
         if (hit && idx == AW'(p)) begin
            if (is_fs)                   rd_word = fs_words[p];
            else if (slot == SLOT_DATA)  rd_word = dat_words[p];
            else if (slot == SLOT_PULL)  rd_word = par_words[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
      else             bus_rdata <= '0;
   end

   // R10: no read strobe, no read data
   p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   // R9: reads outside the map return zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
   localparam int NP = 5;
   localparam int PW = 8;
   localparam int NPIN = NP * PW;
   localparam logic [NPIN-1:0] INIT_PINS = 40'hC3_5A_96_3C_A5;
   localparam logic [NPIN-1:0] LIVE_PINS = 40'h0F_F0_11_22_77;
   localparam logic [NP-1:0]   HAS_PU    = 5'b01011;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic [NPIN-1:0]   pin_in = INIT_PINS;
   logic [NPIN-1:0]   pin_oe, pin_out, pin_pull;
   logic [NPIN*2-1:0] pin_fsel;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done     = 1'b0;
   string cur_req  = "R10";

   always #5 clk = ~clk;

   gpio_bank dut_i (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
      .pin_in (pin_in), .pin_oe (pin_oe), .pin_out (pin_out),
      .pin_pull (pin_pull), .pin_fsel (pin_fsel)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [79:0] act, input logic [79:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [7:0]  m_dir [NP], m_lvl [NP], m_pu [NP], m_snap [NP];
   bit [15:0] m_fs  [NP];
   bit [NPIN-1:0] m_s1, m_s2;
   bit        m_done;
   bit [31:0] m_rd;

   function automatic bit [31:0] m_read(input bit [7:0] a);
      int p, r;
      if (a[1:0] != 2'b00) return 0;
      if (a < 8'h20) begin
         p = a / 4;
         return (p < NP) ? {16'h0, m_fs[p]} : 0;
      end
      p = (a - 8'h20) / 16;
      r = ((a - 8'h20) % 16) / 4;
      if (p >= NP) return 0;
      if (r == 0) return {m_dir[p], m_lvl[p], m_snap[p], m_s2[p*8 +: 8]};
      if (r == 3) return HAS_PU[p] ? {24'h0, m_pu[p]} : 0;
      return 0;
   endfunction

   task automatic m_write(input bit [7:0] a, input bit [31:0] d);
      int p, r;
      if (a[1:0] != 2'b00) return;
      if (a < 8'h20) begin
         p = a / 4;
         if (p < NP) m_fs[p] = d[15:0];
         return;
      end
      p = (a - 8'h20) / 16;
      r = ((a - 8'h20) % 16) / 4;
      if (p >= NP) return;
      case (r)
         0: begin m_dir[p] = d[31:24]; m_lvl[p] = d[23:16]; end
         1: m_lvl[p] = m_lvl[p] | d[7:0];
         2: m_lvl[p] = m_lvl[p] & ~d[7:0];
         default: if (HAS_PU[p]) m_pu[p] = d[7:0];
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_dir[p] = 0; m_lvl[p] = 0; m_fs[p] = 0; m_snap[p] = 0; m_pu[p] = 8'hFF;
         end
         m_done = 0;
         m_rd   = 0;
      end else begin
         m_rd = bus_rd ? m_read(bus_addr) : 0;
         if (!m_done) begin
            for (int p = 0; p < NP; p++) m_snap[p] = m_s2[p*8 +: 8];
            m_done = 1;
         end
         if (bus_wr) m_write(bus_addr, bus_wdata);
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
   end

   // every-cycle comparison, 2 ns after the rising edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         logic [NPIN-1:0]   e_oe, e_out, e_pu;
         logic [NPIN*2-1:0] e_fs;
         for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < PW; i++) begin
               bit g;
               g = (m_fs[p][2*i +: 2] == 2'b00);
               e_oe[p*8+i]  = m_dir[p][i] & g;
               e_out[p*8+i] = m_lvl[p][i] & g;
               e_pu[p*8+i]  = HAS_PU[p] & m_pu[p][i];
            end
            e_fs[p*16 +: 16] = m_fs[p];
         end
         check(pin_oe == e_oe,     "R2", "model pin_oe",  80'(pin_oe),  80'(e_oe));
         check(pin_out == e_out,   "R2", "model pin_out", 80'(pin_out), 80'(e_out));
         check(pin_pull == e_pu,   "R8", "model pin_pull", 80'(pin_pull), 80'(e_pu));
         check(pin_fsel == e_fs,   "R7", "model pin_fsel", 80'(pin_fsel), 80'(e_fs));
         check(bus_rdata == m_rd,  cur_req, "model rdata", 80'(bus_rdata), 80'(m_rd));
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read_expect(input logic [7:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      bus_read(a, d);
      check(d === e, req, $sformatf("read @%h", a), 80'(d), 80'(e));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   // ---------------- directed sequence ----------------
   initial begin
      repeat (5) @(negedge clk);
      // R1: reset values while reset is held
      check(pin_oe == '0 && pin_out == '0 && pin_fsel == '0, "R1", "outputs in reset",
            80'({pin_oe, pin_out}), 80'(0));
      check(pin_pull == 40'h00FF00FFFF, "R1", "pull in reset", 80'(pin_pull), 80'h00FF00FFFF);
      rst_n = 1'b1;
      @(negedge clk);
      pin_in = LIVE_PINS;
      repeat (4) @(negedge clk);
      check(pin_oe == '0 && pin_out == '0, "R1", "outputs after reset",
            80'({pin_oe, pin_out}), 80'(0));

      cur_req = "R5";
      read_expect(8'h20, 32'h0000_A577, "R5");       // snapshot A5, live 77 (R6)
      cur_req = "R8";
      read_expect(8'h2C, 32'h0000_00FF, "R8");
      read_expect(8'h4C, 32'h0000_0000, "R8");       // port 2 has no pull-up

      cur_req = "R2";
      bus_write(8'h20, 32'hF1AA_1234);
      check(pin_oe[7:0] == 8'hF1 && pin_out[7:0] == 8'hAA, "R2", "data write",
            80'({pin_oe[7:0], pin_out[7:0]}), 80'h F1AA);
      read_expect(8'h20, 32'hF1AA_A577, "R2");

      cur_req = "R3";
      bus_write(8'h24, 32'h0000_0005);
      check(pin_out[7:0] == 8'hAF, "R3", "set write", 80'(pin_out[7:0]), 80'hAF);
      read_expect(8'h24, 32'h0, "R9");

      cur_req = "R4";
      bus_write(8'h28, 32'h0000_000A);
      check(pin_out[7:0] == 8'hA5, "R4", "clear write", 80'(pin_out[7:0]), 80'hA5);
      read_expect(8'h28, 32'h0, "R9");

      cur_req = "R7";
      bus_write(8'h00, 32'h0000_0003);
      check(pin_fsel[1:0] == 2'd3 && pin_oe[7:0] == 8'hF0 && pin_out[7:0] == 8'hA4,
            "R7", "alternate function gates pin 0",
            80'({pin_fsel[1:0], pin_oe[7:0], pin_out[7:0]}), 80'h3F0A4);
      read_expect(8'h00, 32'h0000_0003, "R7");
      read_expect(8'h20, 32'hF1A5_A577, "R7");       // stored fields untouched

      cur_req = "R8";
      bus_write(8'h6C, 32'h0000_00FF);
      check(pin_pull[39:32] == 8'h00, "R8", "port 4 pull ignored", 80'(pin_pull[39:32]), 80'h0);
      read_expect(8'h6C, 32'h0, "R8");
      bus_write(8'h3C, 32'h0000_000F);
      check(pin_pull[15:8] == 8'h0F, "R8", "port 1 pull", 80'(pin_pull[15:8]), 80'h0F);
      read_expect(8'h3C, 32'h0000_000F, "R8");

      cur_req = "R2";
      bus_write(8'h50, 32'hFF55_0000);
      check(pin_oe[31:24] == 8'hFF && pin_out[31:24] == 8'h55, "R2", "port 3 data",
            80'({pin_oe[31:24], pin_out[31:24]}), 80'hFF55);
      read_expect(8'h50, 32'hFF55_5AF0, "R2");

      cur_req = "R9";
      bus_write(8'h14, 32'hFFFF_FFFF);
      bus_write(8'h22, 32'h0000_0000);
      bus_write(8'h70, 32'hFFFF_FFFF);
      check(pin_oe[7:0] == 8'hF0 && pin_out[7:0] == 8'hA4, "R9", "unmapped writes ignored",
            80'({pin_oe[7:0], pin_out[7:0]}), 80'hF0A4);
      read_expect(8'h14, 32'h0, "R9");
      read_expect(8'h22, 32'h0, "R9");
      read_expect(8'h70, 32'h0, "R9");

      cur_req = "R6";
      pin_in[7:0] = 8'h3C;
      read_expect(8'h20, 32'hF1A5_A577, "R6");       // strobe too early: old level
      repeat (2) @(negedge clk);
      read_expect(8'h20, 32'hF1A5_A53C, "R6");       // new level, snapshot kept (R5)

      cur_req = "R10";
      repeat (3) @(negedge clk);
      check(bus_rdata == 32'h0, "R10", "idle rdata", 80'(bus_rdata), 80'h0);

      finish_run();
   end
endmodule